// File: doc/BRIEF.md
# Dataflow Frame Synchronization Scheduler

This block keeps a pool of equally sized data frames for threads that never block. A producer allocates a frame for a thread by giving the thread's code pointer and the number of inputs the thread waits for. The block answers at once with the index of a free frame. Other threads then write values into that frame by index and slot offset. Every accepted write lowers the frame's pending-input count by one. When the count reaches zero, the thread pointer and the frame index go into a ready queue.

A single consumer core takes entries from the ready queue. While it holds a thread, that thread is the only one whose frame can be read, addressed by slot offset alone. The core then releases the frame, which goes back into the free pool. Writes that arrive at a frame that is not allocated, or whose count is already zero, are refused and raise an error pulse. Frame count, slots per frame, data width, pointer width and count width are all parameters.

Top module: `dfs_frame_sched`

## Requirements
- R1: After reset `alloc_ready` is 1 and `alloc_frame` shows the frame that the next allocation receives. Frames that have never been used are handed out first, in ascending order from 0. After that, released frames are handed out in the order in which they were released. An allocation never receives a frame that is still live.
- R2: When every frame is live, `alloc_ready` is 0 and an asserted `alloc_valid` has no effect. `alloc_ready` returns to 1 in the cycle after a release.
- R3: The ready queue holds up to NUM_FRAMES entries and never overflows. Entries leave the queue in the order in which their threads became ready.
- R4: A write to a live frame whose count is not zero stores `wr_data` at slot `wr_offset` and lowers the count by one. When that write lowers the count from 1 to 0, exactly one ready entry {thread pointer, frame index} can be seen on `rq_thread`/`rq_frame` in the cycle after the write.
- R5: An allocation with `alloc_count` equal to 0 makes its thread ready. The ready entry can be seen in the cycle after the allocation.
- R6: A write to a frame that is not live raises `wr_error` for one cycle, in the cycle after the write. It makes no ready entry.
- R7: A write to a live frame whose count is already zero raises `wr_error`. It leaves the count, the slot contents and the ready queue unchanged.
- R8: When an allocation and a write name the same frame in the same cycle, the allocation takes effect and the write is refused with `wr_error`. The new count is the full `alloc_count`.
- R9: `rq_valid` is raised only while no thread holds the core. It stays high with a stable payload until `rq_ready` accepts the entry, and accepting it makes that frame the current one. When a write completes one frame in the same cycle as a zero-count allocation, the completed frame is queued first.
- R10: `rd_en` with `rd_offset` returns the slot of the current frame on `rd_data` in the next cycle. When no thread is current, the read returns 0.
- R11: `rel_valid` releases the current frame. The frame returns to the free pool and stops being live, so later writes to it are refused. `rel_valid` has no effect while no thread is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free frame is available |
| alloc_thread | input | PTR_W | Thread code pointer for the new frame |
| alloc_count | input | CNT_W | Number of inputs the thread waits for |
| alloc_frame | output | FIDX_W | Frame index the next allocation receives |
| wr_valid | input | 1 | Frame write request |
| wr_frame | input | FIDX_W | Target frame of the write |
| wr_offset | input | OFF_W | Slot within the target frame |
| wr_data | input | DATA_W | Value to store |
| wr_error | output | 1 | One-cycle pulse for a refused write |
| rq_valid | output | 1 | A ready thread is offered |
| rq_ready | input | 1 | Consumer accepts the offered thread |
| rq_thread | output | PTR_W | Code pointer of the offered thread |
| rq_frame | output | FIDX_W | Frame index of the offered thread |
| rd_en | input | 1 | Read the current frame |
| rd_offset | input | OFF_W | Slot to read |
| rd_data | output | DATA_W | Read result, one cycle after `rd_en` |
| rel_valid | input | 1 | Release the current frame |

## Verification
Some properties are checked on every cycle. Each accepted write lowers its frame's count by exactly one, and a refused write leaves the count untouched. Neither the free pool nor the ready queue overflows or underflows. An allocation never takes a live frame. An offered ready entry holds still until it is accepted, and a read with no current thread returns zero. Other behaviours only the directed scenarios can show, because they depend on history: the order in which fresh frames and recycled frames are handed out, the order of entries in the ready queue when several frames complete, collisions between an allocation and a write to the same frame, and the data read back after a refused write.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

   // Outcome of a frame write, judged in the cycle it is presented
   typedef enum logic [1:0] {
      WV_OK      = 2'd0,
      WV_UNALLOC = 2'd1,
      WV_DRAINED = 2'd2,
      WV_COLLIDE = 2'd3
   } wr_verdict_e;

endpackage

// File: rtl/dfs_free_pool.sv
// Free-frame pool. Behaves as a FIFO that holds every index after reset.
// Indices never used yet come from a counter; released ones wait in a FIFO.
module dfs_free_pool #(
   parameter int NUM_FRAMES = 16,
   parameter int FIDX_W     = $clog2(NUM_FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              push,
   input  logic [FIDX_W-1:0] push_idx,
   output logic              avail,
   output logic [FIDX_W-1:0] head_idx
);
   localparam int CW = FIDX_W + 1;

   logic [CW-1:0]     fresh_q;
   logic [CW-1:0]     cnt_q;
   logic [FIDX_W-1:0] wp_q, rp_q;
   logic [FIDX_W-1:0] ring [NUM_FRAMES];
   logic              fresh_left;

   assign fresh_left = (fresh_q < CW'(NUM_FRAMES));
   assign avail      = fresh_left || (cnt_q != '0);
   assign head_idx   = fresh_left ? fresh_q[FIDX_W-1:0] : ring[rp_q];

   always_ff @(posedge clk) begin
      if (push) ring[wp_q] <= push_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q <= '0;
         cnt_q   <= '0;
         wp_q    <= '0;
         rp_q    <= '0;
      end else begin
         if (pop && fresh_left) fresh_q <= fresh_q + 1'b1;
         if (push) wp_q <= wp_q + 1'b1;
         if (pop && !fresh_left) rp_q <= rp_q + 1'b1;
         case ({push, pop && !fresh_left})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R2: no allocation is taken from an empty pool
   p_pool_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> avail);

   // R11: a release never returns more frames than were handed out
   p_pool_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < fresh_q));

endmodule

// File: rtl/dfs_sync_table.sv
// Per-frame state: whether the frame is live, its pending-input count and
// its thread pointer. Also judges each incoming write.
module dfs_sync_table
   import dfs_pkg::*;
#(
   parameter int NUM_FRAMES = 16,
   parameter int PTR_W      = 32,
   parameter int CNT_W      = 9,
   parameter int FIDX_W     = $clog2(NUM_FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [FIDX_W-1:0] alloc_idx,
   input  logic [PTR_W-1:0]  alloc_thread,
   input  logic [CNT_W-1:0]  alloc_count,
   input  logic              wr_en,
   input  logic [FIDX_W-1:0] wr_idx,
   input  logic              clr_en,
   input  logic [FIDX_W-1:0] clr_idx,
   output wr_verdict_e       verdict,
   output logic              wr_accept,
   output logic              fire,
   output logic [PTR_W-1:0]  fire_thread
);
   logic [NUM_FRAMES-1:0] live;
   logic [CNT_W-1:0]      cnt_arr [NUM_FRAMES];
   logic [PTR_W-1:0]      thr_arr [NUM_FRAMES];

   for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
      logic             live_q;
      logic [CNT_W-1:0] cnt_q;
      logic [PTR_W-1:0] thr_q;
      logic             hit_alloc, hit_clr, hit_wr;

      assign hit_alloc = alloc_en  && (alloc_idx == FIDX_W'(f));
      assign hit_clr   = clr_en    && (clr_idx   == FIDX_W'(f));
      assign hit_wr    = wr_accept && (wr_idx    == FIDX_W'(f));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q <= 1'b0;
            cnt_q  <= '0;
            thr_q  <= '0;
         end else if (hit_alloc) begin
            live_q <= 1'b1;
            cnt_q  <= alloc_count;
            thr_q  <= alloc_thread;
         end else begin
            if (hit_clr) live_q <= 1'b0;
            if (hit_wr)  cnt_q  <= cnt_q - 1'b1;
         end
      end

      assign live[f]    = live_q;
      assign cnt_arr[f] = cnt_q;
      assign thr_arr[f] = thr_q;
   end

   always_comb begin
      if (alloc_en && (alloc_idx == wr_idx)) verdict = WV_COLLIDE;
      else if (!live[wr_idx])                verdict = WV_UNALLOC;
      else if (cnt_arr[wr_idx] == '0)        verdict = WV_DRAINED;
      else                                   verdict = WV_OK;
   end

   assign wr_accept   = wr_en && (verdict == WV_OK);
   assign fire        = wr_accept && (cnt_arr[wr_idx] == CNT_W'(1));
   assign fire_thread = thr_arr[wr_idx];

   // R4: an accepted write lowers its frame's count by exactly one
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> cnt_arr[$past(wr_idx)] == $past(cnt_arr[wr_idx]) - CNT_W'(1));

   // R7: a refused write to an existing frame index leaves its count alone
   p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (verdict == WV_DRAINED || verdict == WV_UNALLOC))
      |=> cnt_arr[$past(wr_idx)] == $past(cnt_arr[wr_idx]));

   // R1: an allocation never lands on a live frame
   p_alloc_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !live[alloc_idx]);

endmodule

// File: rtl/dfs_ready_queue.sv
// Ready queue with two push ports; port 0 is queued ahead of port 1.
module dfs_ready_queue #(
   parameter int DEPTH = 16,
   parameter int ENT_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push0,
   input  logic [ENT_W-1:0] data0,
   input  logic             push1,
   input  logic [ENT_W-1:0] data1,
   input  logic             pop,
   output logic             nonempty,
   output logic [ENT_W-1:0] head
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [ENT_W-1:0] slots [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic [1:0]       n_in;

   assign n_in     = {1'b0, push0} + {1'b0, push1};
   assign nonempty = (cnt_q != '0);
   assign head     = slots[rp_q];

   always_ff @(posedge clk) begin
      if (push0 || push1) slots[wp_q] <= push0 ? data0 : data1;
      if (push0 && push1) slots[wp_q + 1'b1] <= data1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         wp_q  <= wp_q + AW'(n_in);
         if (pop) rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CW'(n_in) - CW'(pop);
      end
   end

   // R3: queue never exceeds its depth
   p_rq_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push0 || push1) |-> (int'(cnt_q) + int'(n_in) - int'(pop)) <= DEPTH);

   // R3: nothing is taken from an empty queue
   p_rq_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty);

endmodule

// File: rtl/dfs_frame_sched.sv
// Frame pool, synchronization countdown and ready dispatch for
// dataflow threads, with a single consumer core.
module dfs_frame_sched
   import dfs_pkg::*;
#(
   parameter int NUM_FRAMES = 16,
   parameter int SLOTS      = 16,
   parameter int DATA_W     = 64,
   parameter int PTR_W      = 32,
   parameter int CNT_W      = 9,
   localparam int FIDX_W    = $clog2(NUM_FRAMES),
   localparam int OFF_W     = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic              alloc_ready,
   input  logic [PTR_W-1:0]  alloc_thread,
   input  logic [CNT_W-1:0]  alloc_count,
   output logic [FIDX_W-1:0] alloc_frame,
   input  logic              wr_valid,
   input  logic [FIDX_W-1:0] wr_frame,
   input  logic [OFF_W-1:0]  wr_offset,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_error,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic [PTR_W-1:0]  rq_thread,
   output logic [FIDX_W-1:0] rq_frame,
   input  logic              rd_en,
   input  logic [OFF_W-1:0]  rd_offset,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rel_valid
);
   localparam int ENT_W  = PTR_W + FIDX_W;
   localparam int ADDR_W = FIDX_W + OFF_W;
   localparam int WORDS  = NUM_FRAMES * SLOTS;

   // Elaboration-time parameter checks
   if (NUM_FRAMES < 2 || (NUM_FRAMES & (NUM_FRAMES - 1)) != 0) begin : g_bad_frames
      $error("NUM_FRAMES must be a power of two of at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (CNT_W < 1 || PTR_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("CNT_W, PTR_W and DATA_W must be positive");
   end

   logic              alloc_fire;
   logic              pool_avail;
   logic [FIDX_W-1:0] pool_head;
   wr_verdict_e       verdict;
   logic              wr_accept, fire;
   logic [PTR_W-1:0]  fire_thread;
   logic              q_nonempty, rq_pop, rel_fire;
   logic [ENT_W-1:0]  q_head;
   logic              cur_active_q;
   logic [FIDX_W-1:0] cur_frame_q;
   logic [DATA_W-1:0] store [WORDS];

   assign alloc_ready = pool_avail;
   assign alloc_frame = pool_head;
   assign alloc_fire  = alloc_valid && pool_avail;
   assign rel_fire    = rel_valid && cur_active_q;
   assign rq_valid    = q_nonempty && !cur_active_q;
   assign rq_pop      = rq_valid && rq_ready;
   assign {rq_thread, rq_frame} = q_head;

   dfs_free_pool #(.NUM_FRAMES(NUM_FRAMES), .FIDX_W(FIDX_W)) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (alloc_fire),
      .push     (rel_fire),
      .push_idx (cur_frame_q),
      .avail    (pool_avail),
      .head_idx (pool_head)
   );

   dfs_sync_table #(
      .NUM_FRAMES(NUM_FRAMES), .PTR_W(PTR_W), .CNT_W(CNT_W), .FIDX_W(FIDX_W)
   ) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_en     (alloc_fire),
      .alloc_idx    (pool_head),
      .alloc_thread (alloc_thread),
      .alloc_count  (alloc_count),
      .wr_en        (wr_valid),
      .wr_idx       (wr_frame),
      .clr_en       (rel_fire),
      .clr_idx      (cur_frame_q),
      .verdict      (verdict),
      .wr_accept    (wr_accept),
      .fire         (fire),
      .fire_thread  (fire_thread)
   );

   dfs_ready_queue #(.DEPTH(NUM_FRAMES), .ENT_W(ENT_W)) u_rq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push0    (fire),
      .data0    ({fire_thread, wr_frame}),
      .push1    (alloc_fire && (alloc_count == '0)),
      .data1    ({alloc_thread, pool_head}),
      .pop      (rq_pop),
      .nonempty (q_nonempty),
      .head     (q_head)
   );

   // Frame storage, written only by accepted writes
   always_ff @(posedge clk) begin
      if (wr_accept) store[ADDR_W'({wr_frame, wr_offset})] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_active_q <= 1'b0;
         cur_frame_q  <= '0;
         wr_error     <= 1'b0;
         rd_data      <= '0;
      end else begin
         wr_error <= wr_valid && !wr_accept;
         if (rq_pop) begin
            cur_active_q <= 1'b1;
            cur_frame_q  <= rq_frame;
         end else if (rel_fire) begin
            cur_active_q <= 1'b0;
         end
         if (rd_en) rd_data <= cur_active_q ? store[{cur_frame_q, rd_offset}] : '0;
      end
   end

   // R9: an offered entry is held unchanged until accepted
   p_rq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && !rq_ready) |=> rq_valid && $stable(rq_thread) && $stable(rq_frame));

   // R10: a read with no current thread yields zero
   p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !cur_active_q) |=> rd_data == '0);

   // R6: a refused write is flagged in the following cycle
   p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && verdict != WV_OK) |=> wr_error);

endmodule

// File: tb/test_dfs_frame_sched.sv
module test_dfs_frame_sched;
   localparam int NF   = 8;
   localparam int NS   = 8;
   localparam int FW   = $clog2(NF);
   localparam int OW   = $clog2(NS);
   localparam int DW   = 64;
   localparam int PW   = 32;
   localparam int CW   = 9;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          alloc_valid, alloc_ready;
   logic [PW-1:0] alloc_thread;
   logic [CW-1:0] alloc_count;
   logic [FW-1:0] alloc_frame;
   logic          wr_valid;
   logic [FW-1:0] wr_frame;
   logic [OW-1:0] wr_offset;
   logic [DW-1:0] wr_data;
   logic          wr_error;
   logic          rq_valid, rq_ready;
   logic [PW-1:0] rq_thread;
   logic [FW-1:0] rq_frame;
   logic          rd_en;
   logic [OW-1:0] rd_offset;
   logic [DW-1:0] rd_data;
   logic          rel_valid;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   dfs_frame_sched #(.NUM_FRAMES(NF), .SLOTS(NS), .DATA_W(DW), .PTR_W(PW), .CNT_W(CW))
   i_dfs_frame_sched (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_thread(alloc_thread),
      .alloc_count(alloc_count), .alloc_frame(alloc_frame),
      .wr_valid(wr_valid), .wr_frame(wr_frame), .wr_offset(wr_offset), .wr_data(wr_data),
      .wr_error(wr_error),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_thread(rq_thread), .rq_frame(rq_frame),
      .rd_en(rd_en), .rd_offset(rd_offset), .rd_data(rd_data),
      .rel_valid(rel_valid)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Advance one cycle: strobes set before this call are sampled at the
   // coming rising edge, then cleared at the next falling edge.
   task automatic step();
      @(negedge clk);
      alloc_valid = 1'b0;
      wr_valid    = 1'b0;
      rq_ready    = 1'b0;
      rd_en       = 1'b0;
      rel_valid   = 1'b0;
   endtask

   task automatic set_alloc(input logic [PW-1:0] thr, input int cnt, input int exp_f,
                            input string req);
      check(alloc_ready == 1'b1, req, alloc_ready, 1);
      check(alloc_frame == FW'(exp_f), req, alloc_frame, exp_f);
      alloc_valid  = 1'b1;
      alloc_thread = thr;
      alloc_count  = CW'(cnt);
   endtask

   task automatic set_write(input int f, input int off, input logic [DW-1:0] d);
      wr_valid  = 1'b1;
      wr_frame  = FW'(f);
      wr_offset = OW'(off);
      wr_data   = d;
   endtask

   task automatic pop_check(input logic [PW-1:0] thr, input int f, input string req);
      check(rq_valid == 1'b1, req, rq_valid, 1);
      check(rq_thread == thr, req, rq_thread, thr);
      check(rq_frame == FW'(f), req, rq_frame, f);
      rq_ready = 1'b1;
      step();
   endtask

   task automatic read_check(input int off, input logic [DW-1:0] exp, input string req);
      rd_en     = 1'b1;
      rd_offset = OW'(off);
      step();
      check(rd_data == exp, req, rd_data, exp);
   endtask

   task automatic release_cur();
      rel_valid = 1'b1;
      step();
   endtask

   task automatic t_reset();
      check(alloc_ready == 1'b1, "R1 reset alloc_ready", alloc_ready, 1);
      check(alloc_frame == '0, "R1 reset first frame", alloc_frame, 0);
      check(rq_valid == 1'b0, "R9 reset rq_valid", rq_valid, 0);
      check(wr_error == 1'b0, "R6 reset wr_error", wr_error, 0);
      check(rd_data == '0, "R10 reset rd_data", rd_data, 0);
   endtask

   task automatic t_basic();
      set_alloc(32'h100, 2, 0, "R1 first alloc");
      step();
      check(rq_valid == 1'b0, "R4 not ready with count 2", rq_valid, 0);
      set_write(0, 3, 64'hD1D1_0000_0000_0003);
      step();
      check(wr_error == 1'b0, "R4 accepted write", wr_error, 0);
      check(rq_valid == 1'b0, "R4 count 1 not ready", rq_valid, 0);
      set_write(0, 5, 64'hD2D2_0000_0000_0005);
      step();
      pop_check(32'h100, 0, "R4 ready after last write");
      check(rq_valid == 1'b0, "R4 single entry", rq_valid, 0);
      read_check(3, 64'hD1D1_0000_0000_0003, "R10 read slot 3");
      read_check(5, 64'hD2D2_0000_0000_0005, "R10 read slot 5");
      release_cur();
      set_write(0, 1, 64'h1);
      step();
      check(wr_error == 1'b1, "R11 write to released frame", wr_error, 1);
      step();
      check(wr_error == 1'b0, "R6 error lasts one cycle", wr_error, 0);
      set_write(7, 0, 64'h2);
      step();
      check(wr_error == 1'b1, "R6 write to never-used frame", wr_error, 1);
      check(rq_valid == 1'b0, "R6 no ready entry", rq_valid, 0);
   endtask

   task automatic t_zero();
      set_alloc(32'h200, 0, 1, "R1 second alloc");
      step();
      pop_check(32'h200, 1, "R5 zero-count alloc ready");
      release_cur();
      read_check(0, 64'h0, "R10 read with no current thread");
      rel_valid = 1'b1;
      step();
      check(alloc_frame == FW'(2), "R11 idle release ignored", alloc_frame, 2);
   endtask

   task automatic t_drained();
      set_alloc(32'h300, 1, 2, "R1 third alloc");
      step();
      set_write(2, 0, 64'hAAAA);
      step();
      check(rq_valid == 1'b1, "R4 ready", rq_valid, 1);
      set_write(2, 0, 64'hBBBB);
      step();
      check(wr_error == 1'b1, "R7 write to drained frame", wr_error, 1);
      pop_check(32'h300, 2, "R9 entry held across refused write");
      check(rq_valid == 1'b0, "R7 no second entry", rq_valid, 0);
      read_check(0, 64'hAAAA, "R7 slot unchanged");
      release_cur();
   endtask

   task automatic t_collide();
      set_alloc(32'h400, 1, 3, "R1 fourth alloc");
      set_write(3, 2, 64'hCCCC);
      step();
      check(wr_error == 1'b1, "R8 colliding write refused", wr_error, 1);
      check(rq_valid == 1'b0, "R8 count kept", rq_valid, 0);
      set_write(3, 2, 64'hEEEE);
      step();
      check(wr_error == 1'b0, "R8 later write accepted", wr_error, 0);
      pop_check(32'h400, 3, "R8 ready after one write");
      read_check(2, 64'hEEEE, "R8 data of accepted write");
      release_cur();
   endtask

   task automatic t_order();
      set_alloc(32'h500, 1, 4, "R1 alloc 4");
      step();
      set_alloc(32'h600, 1, 5, "R1 alloc 5");
      step();
      set_alloc(32'h700, 1, 6, "R1 alloc 6");
      step();
      set_write(5, 0, 64'h5);
      step();
      set_write(4, 0, 64'h4);
      step();
      set_write(6, 0, 64'h6);
      set_alloc(32'h800, 0, 7, "R1 alloc 7");
      step();
      pop_check(32'h600, 5, "R3 first completed first");
      check(rq_valid == 1'b0, "R9 no offer while busy", rq_valid, 0);
      release_cur();
      pop_check(32'h500, 4, "R3 second in order");
      release_cur();
      pop_check(32'h700, 6, "R9 write completion before alloc");
      release_cur();
      pop_check(32'h800, 7, "R9 zero-count alloc after");
      release_cur();
      check(rq_valid == 1'b0, "R3 queue drained", rq_valid, 0);
   endtask

   task automatic t_exhaust();
      int order [8] = '{0, 1, 2, 3, 5, 4, 6, 7};
      for (int i = 0; i < NF; i++) begin
         set_alloc(32'h900 + PW'(i), 1, order[i], "R1 recycle order");
         step();
      end
      check(alloc_ready == 1'b0, "R2 pool empty", alloc_ready, 0);
      alloc_valid  = 1'b1;
      alloc_thread = 32'hDEAD;
      alloc_count  = '0;
      step();
      check(rq_valid == 1'b0, "R2 alloc while empty ignored", rq_valid, 0);
      check(alloc_ready == 1'b0, "R2 still empty", alloc_ready, 0);
      set_write(0, 0, 64'h77);
      step();
      pop_check(32'h900, 0, "R2 frame 0 ready");
      release_cur();
      check(alloc_ready == 1'b1, "R2 ready after release", alloc_ready, 1);
      check(alloc_frame == '0, "R2 released frame offered", alloc_frame, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n        = 1'b0;
      alloc_valid  = 1'b0;
      alloc_thread = '0;
      alloc_count  = '0;
      wr_valid     = 1'b0;
      wr_frame     = '0;
      wr_offset    = '0;
      wr_data      = '0;
      rq_ready     = 1'b0;
      rd_en        = 1'b0;
      rd_offset    = '0;
      rel_valid    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_zero();
      t_drained();
      t_collide();
      t_order();
      t_exhaust();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule